// File: doc/BRIEF.md
# Keyed Register Write Gate

This block guards a peripheral's register file against stray writes. It sits between a simple single-cycle write port and the registers. For each write it produces a qualified write strobe. Writes to the guarded registers reach them only after software has opened the gate.

To open the gate, software writes two key bytes, in a fixed order, to a dedicated key register. Any other write to that register closes the gate again. Software opens the gate, programs the guarded registers, then writes a wrong key to close it. Writes to registers outside the guarded set pass through at all times. Writes to the key register itself are used up by the gate and are never forwarded.

Top module: `regwr_guard`

## Requirements
- R1: After reset the gate is closed: `unlocked` reads 0.
- R2: A write of 0xCA to the key register (offset 0x24), followed by a write of 0x53 as the next key-register write, opens the gate. `unlocked` goes to 1 from the cycle after the second write.
- R3: After a first key of 0xCA, a key-register write of any value other than 0x53 closes the gate. This includes a second 0xCA. A following 0x53 alone does not open it.
- R4: While the gate is open, any key-register write closes it. A write of 0xCA in this state also counts as the first key of a new sequence.
- R5: Only bits [7:0] of a key-register write are compared with the key values. The upper data bits have no effect.
- R6: A write to a guarded offset (0x00, 0x04, 0x0C, 0x10, 0x18) raises `wr_allow` in the same cycle only while the gate is open. While the gate is closed the write is dropped.
- R7: A write to any offset that is neither guarded nor the key register raises `wr_allow` in the same cycle, whatever the gate state.
- R8: A write to the key register never raises `wr_allow`.
- R9: Writes to offsets other than the key register leave the gate state unchanged. A dropped guarded write keeps the gate closed. Such writes between the two key bytes do not break the sequence.
- R10: With `wr_en` low, nothing changes: `wr_allow` stays 0 and the address and data lines have no effect on the gate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Single-cycle write strobe from the bus |
| wr_addr | input | ADDR_W (8) | Register offset of the write |
| wr_data | input | DATA_W (32) | Write data; bits [7:0] are checked on key writes |
| wr_allow | output | 1 | Qualified write strobe toward the register file |
| unlocked | output | 1 | High while guarded registers may be written |

## Verification
The bench targets three kinds of error.

- Sequence handling: it sends 0xCA twice and then 0x53. A sequencer that treats a repeated first key as "still armed" would open here, but it must stay closed. It also sends a key-register write while the gate is open; a design that ignores re-keying would stay open.
- Key data width: it hides the key bytes under non-zero upper data bits. A design that compares the full word would never open.
- Leakage and state: it sends key and guarded writes with the strobe low, which a careless decoder would act on. It puts dropped guarded writes and unrelated writes between the two key bytes; a design that resets the sequence on any write, or forwards key writes, shows up at `wr_allow` or `unlocked`.

// File: rtl/wp_gate_pkg.sv
`timescale 1ns/1ps
package wp_gate_pkg;

  typedef enum logic [1:0] {
    GATE_LOCKED = 2'd0,
    GATE_ARMED  = 2'd1,
    GATE_OPEN   = 2'd2
  } gate_state_e;

  localparam int unsigned DEF_ADDR_W = 8;
  localparam int unsigned DEF_DATA_W = 32;
  localparam int unsigned DEF_KEY_W  = 8;

endpackage

// File: rtl/wp_rst_sync.sv
`timescale 1ns/1ps
module wp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_in_n,
  output logic rst_out_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_out_n = sync_q[STAGES-1];

endmodule

// File: rtl/wp_addr_decode.sv
`timescale 1ns/1ps
module wp_addr_decode #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned NUM_PROT = 5,
  parameter logic [NUM_PROT-1:0][ADDR_W-1:0] PROT_OFS = '0,
  parameter logic [ADDR_W-1:0] KEY_OFS = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_prot,
  output logic              hit_key
);

  logic [NUM_PROT-1:0] match;

  // one comparator per guarded offset
  for (genvar g = 0; g < NUM_PROT; g++) begin : g_cmp
    assign match[g] = (addr == PROT_OFS[g]);
  end

  assign hit_prot = |match;
  assign hit_key  = (addr == KEY_OFS);

endmodule

// File: rtl/wp_key_seq.sv
`timescale 1ns/1ps
module wp_key_seq
  import wp_gate_pkg::*;
#(
  parameter int unsigned KEY_W = 8,
  parameter logic [KEY_W-1:0] KEY_FIRST  = 8'hCA,
  parameter logic [KEY_W-1:0] KEY_SECOND = 8'h53
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_wr,
  input  logic [KEY_W-1:0] key_byte,
  output logic             open
);

  gate_state_e state_q, state_d;
  logic        state_en;

  // state only moves on a key-register write
  assign state_en = key_wr;

  always_comb begin
    state_d = GATE_LOCKED;
    unique case (state_q)
      GATE_LOCKED: state_d = (key_byte == KEY_FIRST)  ? GATE_ARMED : GATE_LOCKED;
      GATE_ARMED:  state_d = (key_byte == KEY_SECOND) ? GATE_OPEN  : GATE_LOCKED;
      GATE_OPEN:   state_d = (key_byte == KEY_FIRST)  ? GATE_ARMED : GATE_LOCKED;
      default:     state_d = GATE_LOCKED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= GATE_LOCKED;
    else if (state_en) state_q <= state_d;
  end

  assign open = (state_q == GATE_OPEN);

endmodule

// File: rtl/regwr_guard.sv
`timescale 1ns/1ps
module regwr_guard
  import wp_gate_pkg::*;
#(
  parameter int unsigned ADDR_W   = DEF_ADDR_W,
  parameter int unsigned DATA_W   = DEF_DATA_W,
  parameter int unsigned KEY_W    = DEF_KEY_W,
  parameter int unsigned NUM_PROT = 5,
  parameter logic [NUM_PROT-1:0][ADDR_W-1:0] PROT_OFS =
    {8'h18, 8'h10, 8'h0C, 8'h04, 8'h00},
  parameter logic [ADDR_W-1:0] KEY_OFS    = 8'h24,
  parameter logic [KEY_W-1:0]  KEY_FIRST  = 8'hCA,
  parameter logic [KEY_W-1:0]  KEY_SECOND = 8'h53
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_allow,
  output logic              unlocked
);

  localparam int unsigned HI_W = DATA_W - KEY_W;

  logic rst_core_n;
  logic hit_prot;
  logic hit_key;
  logic key_wr;
  logic [HI_W-1:0] unused_hi;

  assign unused_hi = wr_data[DATA_W-1:KEY_W];

  wp_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_in_n  (rst_n),
    .rst_out_n (rst_core_n)
  );

  wp_addr_decode #(
    .ADDR_W   (ADDR_W),
    .NUM_PROT (NUM_PROT),
    .PROT_OFS (PROT_OFS),
    .KEY_OFS  (KEY_OFS)
  ) u_dec (
    .addr     (wr_addr),
    .hit_prot (hit_prot),
    .hit_key  (hit_key)
  );

  assign key_wr = wr_en & hit_key;

  wp_key_seq #(
    .KEY_W      (KEY_W),
    .KEY_FIRST  (KEY_FIRST),
    .KEY_SECOND (KEY_SECOND)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .key_wr   (key_wr),
    .key_byte (wr_data[KEY_W-1:0]),
    .open     (unlocked)
  );

  // qualified strobe: key writes are consumed, guarded writes need the open gate
  assign wr_allow = wr_en & ~hit_key & (~hit_prot | unlocked);

endmodule

// File: rtl/wp_guard_chk.sv
`timescale 1ns/1ps
module wp_guard_chk #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned KEY_W    = 8,
  parameter int unsigned NUM_PROT = 5,
  parameter logic [NUM_PROT-1:0][ADDR_W-1:0] PROT_OFS = '0,
  parameter logic [ADDR_W-1:0] KEY_OFS    = '0,
  parameter logic [KEY_W-1:0]  KEY_SECOND = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [KEY_W-1:0]  key_byte,
  input logic              wr_allow,
  input logic              unlocked
);

  logic is_prot;
  always_comb begin
    is_prot = 1'b0;
    for (int i = 0; i < NUM_PROT; i++)
      if (wr_addr == PROT_OFS[i]) is_prot = 1'b1;
  end

  // R8
  key_never_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == KEY_OFS) |-> !wr_allow);

  // R6
  prot_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_prot && !unlocked) |-> !wr_allow);

  // R2
  open_on_second_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(wr_en && wr_addr == KEY_OFS && key_byte == KEY_SECOND));

  // R4
  relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && wr_en && wr_addr == KEY_OFS) |=> !unlocked);

  // R9
  state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == KEY_OFS) |=> $stable(unlocked));

  // R10
  idle_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> !wr_allow);

endmodule

bind regwr_guard wp_guard_chk #(
  .ADDR_W     (ADDR_W),
  .KEY_W      (KEY_W),
  .NUM_PROT   (NUM_PROT),
  .PROT_OFS   (PROT_OFS),
  .KEY_OFS    (KEY_OFS),
  .KEY_SECOND (KEY_SECOND)
) u_guard_chk (
  .clk      (clk),
  .rst_n    (rst_core_n),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .key_byte (wr_data[KEY_W-1:0]),
  .wr_allow (wr_allow),
  .unlocked (unlocked)
);

// File: tb/test_regwr_guard.sv
`timescale 1ns/1ps
module test_regwr_guard;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [7:0]  wr_addr;
  logic [31:0] wr_data;
  logic        wr_allow;
  logic        unlocked;

  regwr_guard i_regwr_guard (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wr_allow (wr_allow),
    .unlocked (unlocked)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct {
    logic  allow;
    logic  unl;
    string req;
  } exp_t;

  exp_t exp_q[$];
  int   n_vec  = 0;
  int   n_fail = 0;
  int   m_st   = 0;   // 0 closed, 1 first key seen, 2 open
  bit   done   = 0;

  function automatic bit is_prot(input logic [7:0] a);
    return (a == 8'h00) || (a == 8'h04) || (a == 8'h0C) || (a == 8'h10) || (a == 8'h18);
  endfunction

  task automatic drive(input logic en, input logic [7:0] a, input logic [31:0] d, input string req);
    exp_t e;
    @(negedge clk);
    wr_en   = en;
    wr_addr = a;
    wr_data = d;
    e.unl   = (m_st == 2);
    e.allow = en && (a != 8'h24) && (!is_prot(a) || m_st == 2);
    e.req   = req;
    exp_q.push_back(e);
    if (en && a == 8'h24) begin
      case (m_st)
        1:       m_st = (d[7:0] == 8'h53) ? 2 : 0;
        default: m_st = (d[7:0] == 8'hCA) ? 1 : 0;
      endcase
    end
  endtask

  // monitor: compare each driven vector just before the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_vec++;
        if (wr_allow !== e.allow || unlocked !== e.unl) begin
          n_fail++;
          $display("FAIL %s: wr_allow=%b unlocked=%b expected wr_allow=%b unlocked=%b",
                   e.req, wr_allow, unlocked, e.allow, e.unl);
        end
      end
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #2;
    n_vec++;
    if (unlocked !== 1'b0 || wr_allow !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: unlocked=%b wr_allow=%b expected 0 0", unlocked, wr_allow);
    end

    // R10: key bytes with strobe low do nothing
    drive(0, 8'h24, 32'hCA, "R10");
    drive(0, 8'h24, 32'h53, "R10");
    drive(0, 8'h00, 32'h1,  "R10");
    drive(0, 8'h08, 32'h1,  "R10");
    // R6 closed: guarded dropped; R7 others pass; R9 state kept
    drive(1, 8'h00, 32'h11, "R6");
    drive(1, 8'h18, 32'h11, "R9");
    drive(1, 8'h08, 32'h22, "R7");
    drive(1, 8'h30, 32'h22, "R7");
    // R2 open, R8 key writes not forwarded
    drive(1, 8'h24, 32'hCA, "R8");
    drive(1, 8'h24, 32'h53, "R2");
    drive(1, 8'h00, 32'h1,  "R6");
    drive(1, 8'h04, 32'h1,  "R6");
    drive(1, 8'h0C, 32'h1,  "R6");
    drive(1, 8'h10, 32'h1,  "R6");
    drive(1, 8'h18, 32'h1,  "R6");
    drive(1, 8'h2C, 32'h1,  "R7");
    // R4 wrong key closes
    drive(1, 8'h24, 32'hFF, "R4");
    drive(1, 8'h10, 32'h5,  "R4");
    // R3 repeated first key
    drive(1, 8'h24, 32'hCA, "R3");
    drive(1, 8'h24, 32'hCA, "R3");
    drive(1, 8'h24, 32'h53, "R3");
    drive(1, 8'h00, 32'h5,  "R3");
    drive(1, 8'h24, 32'hCA, "R3");
    drive(1, 8'h24, 32'h00, "R3");
    drive(1, 8'h24, 32'h53, "R3");
    drive(1, 8'h04, 32'h5,  "R3");
    // R5 upper bits ignored
    drive(1, 8'h24, 32'hABCD_12CA, "R5");
    drive(1, 8'h24, 32'hFFFF_FF53, "R5");
    drive(1, 8'h0C, 32'h7,         "R5");
    // R4 first key while open relocks and re-arms
    drive(1, 8'h24, 32'hCA, "R4");
    drive(1, 8'h0C, 32'h7,  "R4");
    drive(1, 8'h24, 32'h53, "R4");
    drive(1, 8'h0C, 32'h7,  "R4");
    // R9 other writes between key bytes keep the sequence
    drive(1, 8'h24, 32'hFF, "R9");
    drive(1, 8'h24, 32'hCA, "R9");
    drive(1, 8'h0C, 32'h9,  "R9");
    drive(1, 8'h08, 32'h9,  "R9");
    drive(0, 8'h24, 32'hFF, "R10");
    drive(1, 8'h24, 32'h53, "R9");
    drive(1, 8'h18, 32'h9,  "R9");
    drive(1, 8'h24, 32'h00, "R4");
    drive(0, 8'h00, 32'h0,  "R10");
    drive(0, 8'h00, 32'h0,  "R10");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: %0d items left, expected 0", exp_q.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule